// File: doc/BRIEF.md
# External Interrupt Edge Timestamper

This block turns activity on a bank of general-purpose input pins into interrupt requests for three external interrupt channels. Each channel watches one pin that software chooses from the bank. It reacts to falling edges, rising edges or both, depending on its configuration, and it has its own enable. Every channel also runs a free-running up counter. A valid trigger edge clears the counter to zero, so reading it back later gives the number of clock cycles since that channel's last event.

All pins are first brought into the clock domain through a two-stage synchroniser. Edges are then detected per pin, so changing a channel's pin selection never creates an edge by itself. The channel at index `NMI_CH` (the third channel by default) has a routing bit. This bit sends its request either to the ordinary maskable request output or to a separate non-maskable output. Configuration is written one channel at a time through a simple write strobe. Counters are read back through a channel-select mux.

Top module: `xint_stamp`

## Requirements
- R1: While reset is asserted, `irq_o` and `nmi_o` are 0 and every counter reads 0. After reset every channel is disabled, so pin activity raises no request.
- R2: A pin change on a selected, enabled channel is visible on the request output only after the third rising clock edge following the change. Nothing appears after the second edge. The request lasts exactly one cycle for a single edge.
- R3: Polarity code 2'b00 (config bits [2:1]) triggers on a falling edge only.
- R4: Polarity code 2'b01 triggers on a rising edge only.
- R5: Polarity code 2'b11 triggers on both rising and falling edges.
- R6: Polarity code 2'b10 triggers on no edge.
- R7: With the enable bit (config bit [0]) cleared, edges raise no request and leave the counter counting on.
- R8: The pin-select field (config bits [7:3]) picks any one of the 32 pins. Edges on other pins do not affect that channel.
- R9: Each counter increments by one on every clock. In the cycle its request appears, the counter reads 0.
- R10: A counter wraps from 16'hFFFF to 0 without raising a request.
- R11: For channel 2, routing bit 1 (config bit [8]) sends its request to `nmi_o` instead of `irq_o[2]`. The same bit on channels 0 and 1 has no effect. `nmi_o` and `irq_o[2]` are never high together.
- R12: `rd_cnt_o` shows the counter of the channel chosen by `rd_ch_i`. A select value with no channel returns 0.
- R13: Selecting a pin that is already steady at 1 raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gpio_i | input | NUM_PINS (32) | Asynchronous pin bank |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel addressed by the write |
| cfg_wdata_i | input | 9 | {route, pin select[4:0], polarity[1:0], enable} |
| rd_ch_i | input | 2 | Channel whose counter is read back |
| rd_cnt_o | output | 16 | Counter of the selected channel |
| irq_o | output | NUM_CH (3) | Maskable request pulses, one per channel |
| nmi_o | output | 1 | Non-maskable request pulse from the routable channel |

## Verification
The bench sweeps every channel through every polarity code, with the enable both set and cleared, over rising and falling transitions. It checks the exact cycle of each request and the counter value at that cycle. A wrong polarity decode, or a disabled channel that still clears its counter, shows up as a request or counter value that does not match. A sweep over all 32 pin selections, with the other channels watching neighbouring pins, catches a mux that picks the wrong pin or leaks between channels. The bench also reselects a channel onto a pin that is already high. A design that kept edge history per channel instead of per pin would fire a spurious request there. Further cases cover the full 65536-cycle counter wrap and the routing bit on the routable and non-routable channels.

// File: rtl/xint_stamp_pkg.sv
package xint_stamp_pkg;

  typedef enum logic [1:0] {
    POL_FALL = 2'b00,
    POL_RISE = 2'b01,
    POL_NONE = 2'b10,
    POL_BOTH = 2'b11
  } pol_e;

  // Decide whether a detected transition counts for the given polarity.
  function automatic logic edge_hit(pol_e pol, logic rise, logic fall);
    logic hit;
    case (pol)
      POL_FALL: hit = fall;
      POL_RISE: hit = rise;
      POL_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/xint_rst_sync.sv
module xint_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_no = stage_q[1];

endmodule

// File: rtl/xint_pin_sync.sv
module xint_pin_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);

  // Per pin: two metastability stages plus one history stage.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [2:0] sh_q;
    logic [2:0] sh_d;

    always_comb begin
      sh_d = {sh_q[1:0], pin_i[p]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= 3'b000;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign rise_o[p] =  sh_q[1] & ~sh_q[2];
    assign fall_o[p] = ~sh_q[1] &  sh_q[2];
  end

endmodule

// File: rtl/xint_chan.sv
module xint_chan
  import xint_stamp_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 16,
  localparam int SEL_W   = $clog2(NUM_PINS),
  localparam int CFG_W   = SEL_W + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CFG_W-1:0]    wr_data_i,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  output logic                fire_o,
  output logic                en_o,
  output logic                route_o,
  output logic [CNT_W-1:0]    cnt_o
);

  logic             en_q, en_d;
  pol_e             pol_q, pol_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             route_q, route_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire_q, fire_d;
  logic             hit;

  // Configuration next state
  always_comb begin
    en_d    = en_q;
    pol_d   = pol_q;
    sel_d   = sel_q;
    route_d = route_q;
    if (wr_en_i) begin
      en_d    = wr_data_i[0];
      pol_d   = pol_e'(wr_data_i[2:1]);
      sel_d   = wr_data_i[SEL_W+2:3];
      route_d = wr_data_i[SEL_W+3];
    end
  end

  // Edge qualification and timestamp counter next state
  always_comb begin
    hit    = en_q & edge_hit(pol_q, rise_i[sel_q], fall_i[sel_q]);
    fire_d = hit;
    cnt_d  = hit ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pol_q   <= POL_FALL;
      sel_q   <= '0;
      route_q <= 1'b0;
    end else if (wr_en_i) begin
      en_q    <= en_d;
      pol_q   <= pol_d;
      sel_q   <= sel_d;
      route_q <= route_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire_o  = fire_q;
  assign en_o    = en_q;
  assign route_o = route_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/xint_stamp.sv
module xint_stamp #(
  parameter int NUM_PINS = 32,
  parameter int NUM_CH   = 3,
  parameter int CNT_W    = 16,
  parameter int NMI_CH   = 2,
  localparam int SEL_W   = $clog2(NUM_PINS),
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int CFG_W   = SEL_W + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic                cfg_we_i,
  input  logic [CH_W-1:0]     cfg_ch_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic [CH_W-1:0]     rd_ch_i,
  output logic [CNT_W-1:0]    rd_cnt_o,
  output logic [NUM_CH-1:0]   irq_o,
  output logic                nmi_o
);

  logic                         rst_n_q;
  logic [NUM_PINS-1:0]          rise;
  logic [NUM_PINS-1:0]          fall;
  logic [NUM_CH-1:0]            fire;
  logic [NUM_CH-1:0]            route;
  logic [NUM_CH-1:0]            en_all;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  xint_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  xint_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .pin_i  (gpio_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic IS_NMI = (c == NMI_CH);
    logic wr_sel;

    assign wr_sel = cfg_we_i && (cfg_ch_i == CH_W'(c));

    xint_chan #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_q),
      .wr_en_i   (wr_sel),
      .wr_data_i (cfg_wdata_i),
      .rise_i    (rise),
      .fall_i    (fall),
      .fire_o    (fire[c]),
      .en_o      (en_all[c]),
      .route_o   (route[c]),
      .cnt_o     (cnt_all[c])
    );

    assign irq_o[c] = fire[c] & ~(route[c] & IS_NMI);
  end

  assign nmi_o = fire[NMI_CH] & route[NMI_CH];

  always_comb begin
    rd_cnt_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ch_i == CH_W'(c)) begin
        rd_cnt_o = cnt_all[c];
      end
    end
  end

endmodule

// File: rtl/xint_stamp_chk.sv
module xint_stamp_chk #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int NMI_CH = 2
) (
  input logic                         clk_i,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            irq_o,
  input logic                         nmi_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0]            en_all
);

  logic [NUM_CH-1:0] fired;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    if (c == NMI_CH) begin : g_nmi
      assign fired[c] = irq_o[c] | nmi_o;
    end else begin : g_plain
      assign fired[c] = irq_o[c];
    end

    // R9: the counter is zero whenever its channel reports an event
    a_r9_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
      fired[c] |-> (cnt_all[c] == '0));

    // R9 / R10: otherwise it steps by one, wrapping at the top
    a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_n)
      1'b1 |=> (fired[c] ? (cnt_all[c] == '0)
                         : (cnt_all[c] == CNT_W'($past(cnt_all[c]) + 1'b1))));

    // R7: a disabled channel reports nothing in the following cycle
    a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
      !en_all[c] |=> !fired[c]);
  end

  // R11: one event never shows on both the maskable and non-maskable line
  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(nmi_o && irq_o[NMI_CH]));

endmodule

bind xint_stamp xint_stamp_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .NMI_CH (NMI_CH)
) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_q),
  .irq_o   (irq_o),
  .nmi_o   (nmi_o),
  .cnt_all (cnt_all),
  .en_all  (en_all)
);

// File: tb/xint_stamp_bench.sv
`timescale 1ns/1ps
module xint_stamp_bench;

  logic        clk;
  logic        rst_ni;
  logic [31:0] gpio;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [8:0]  cfg_wdata;
  logic [1:0]  rd_ch;
  logic [15:0] rd_cnt;
  logic [2:0]  irq;
  logic        nmi;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  xint_stamp u_xint_stamp (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .gpio_i      (gpio),
    .cfg_we_i    (cfg_we),
    .cfg_ch_i    (cfg_ch),
    .cfg_wdata_i (cfg_wdata),
    .rd_ch_i     (rd_ch),
    .rd_cnt_o    (rd_cnt),
    .irq_o       (irq),
    .nmi_o       (nmi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // {route, sel[4:0], pol[1:0], en}
  task automatic wrcfg(input int ch, input bit en, input int pol, input int sel, input bit route);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_ch    = 2'(ch);
    cfg_wdata = {route, 5'(sel), 2'(pol), en};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Drive a pin, then check the request timing (R2) and the counter (R9).
  task automatic watch(input int pin, input bit val, input int ch,
                       input logic [2:0] exp_irq, input bit exp_nmi,
                       input bit exp_clear, input string req);
    logic [15:0] c0;
    logic [15:0] exp_cnt;
    @(negedge clk);
    gpio[pin] = val;
    rd_ch     = 2'(ch);
    #1;
    c0 = rd_cnt;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk(irq == 3'b000 && !nmi, "R2 early", {irq, nmi}, 0);
    @(posedge clk);
    #1;
    chk(irq == exp_irq, req, irq, exp_irq);
    chk(nmi == exp_nmi, req, nmi, exp_nmi);
    exp_cnt = exp_clear ? 16'h0000 : 16'(c0 + 16'd3);
    chk(rd_cnt == exp_cnt, "R9 count", rd_cnt, exp_cnt);
    @(posedge clk);
    #1;
    chk(irq == 3'b000 && !nmi, "R2 pulse", {irq, nmi}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni    = 1'b0;
    gpio      = '0;
    cfg_we    = 1'b0;
    cfg_ch    = '0;
    cfg_wdata = '0;
    rd_ch     = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 3; c++) begin
      rd_ch = 2'(c);
      #0.1;
      chk(rd_cnt == 16'h0, "R1 counter", rd_cnt, 0);
    end
    chk(irq == 3'b000 && !nmi, "R1 requests", {irq, nmi}, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);

    // R1: channels start disabled
    watch(0, 1'b1, 0, 3'b000, 1'b0, 1'b0, "R1 disabled");
    watch(0, 1'b0, 0, 3'b000, 1'b0, 1'b0, "R1 disabled");

    // Polarity and enable sweep on every channel (R3 R4 R5 R6 R7)
    for (int ch = 0; ch < 3; ch++) begin
      for (int pol = 0; pol < 4; pol++) begin
        for (int en = 0; en < 2; en++) begin
          string tag;
          bit    fr;
          bit    ff;
          case (pol)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R6";
            default: tag = "R5";
          endcase
          if (en == 0) tag = "R7";
          fr = (en == 1) && (pol == 1 || pol == 3);
          ff = (en == 1) && (pol == 0 || pol == 3);
          wrcfg(ch, en[0], pol, ch, 1'b0);
          watch(ch, 1'b1, ch, 3'(fr) << ch, 1'b0, fr, tag);
          watch(ch, 1'b0, ch, 3'(ff) << ch, 1'b0, ff, tag);
          wrcfg(ch, 1'b0, 0, ch, 1'b0);
        end
      end
    end

    // R8: every pin selection, neighbours watching other pins
    for (int p = 0; p < 32; p++) begin
      wrcfg(0, 1'b1, 1, p, 1'b0);
      wrcfg(1, 1'b1, 1, (p + 1) % 32, 1'b0);
      wrcfg(2, 1'b1, 1, (p + 2) % 32, 1'b0);
      watch(p, 1'b1, 0, 3'b001, 1'b0, 1'b1, "R8");
      watch(p, 1'b0, 0, 3'b000, 1'b0, 1'b0, "R8");
    end
    for (int c = 0; c < 3; c++) wrcfg(c, 1'b0, 0, 0, 1'b0);

    // R13: reselecting onto a pin already high
    wrcfg(0, 1'b1, 1, 7, 1'b0);
    watch(8, 1'b1, 0, 3'b000, 1'b0, 1'b0, "R13 other pin");
    wrcfg(0, 1'b1, 1, 8, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #1;
      chk(irq == 3'b000, "R13 reselect", irq, 0);
    end
    watch(8, 1'b0, 0, 3'b000, 1'b0, 1'b0, "R13 fall");
    wrcfg(0, 1'b0, 0, 0, 1'b0);

    // R11: routing of the third channel, and no effect on channel 0
    wrcfg(2, 1'b1, 1, 5, 1'b1);
    watch(5, 1'b1, 2, 3'b000, 1'b1, 1'b1, "R11 nmi");
    watch(5, 1'b0, 2, 3'b000, 1'b0, 1'b0, "R11 nmi");
    wrcfg(2, 1'b1, 1, 5, 1'b0);
    watch(5, 1'b1, 2, 3'b100, 1'b0, 1'b1, "R11 maskable");
    wrcfg(0, 1'b1, 1, 6, 1'b1);
    watch(6, 1'b1, 0, 3'b001, 1'b0, 1'b1, "R11 ignored");
    wrcfg(0, 1'b0, 0, 0, 1'b0);
    wrcfg(2, 1'b0, 0, 0, 1'b0);

    // R12: unused select value reads zero
    @(negedge clk);
    rd_ch = 2'd3;
    #1;
    chk(rd_cnt == 16'h0, "R12 empty select", rd_cnt, 0);
    rd_ch = 2'd0;
    #0.1;
    chk(rd_cnt != 16'h0, "R12 live select", rd_cnt, 1);

    // R10: wrap after a full period
    wrcfg(1, 1'b1, 1, 9, 1'b0);
    watch(9, 1'b1, 1, 3'b010, 1'b0, 1'b1, "R10 start");
    repeat (65534) @(posedge clk);
    #1;
    chk(rd_cnt == 16'hFFFF, "R10 top", rd_cnt, 16'hFFFF);
    @(posedge clk);
    #1;
    chk(rd_cnt == 16'h0000, "R10 wrap", rd_cnt, 0);
    chk(irq == 3'b000 && !nmi, "R10 no request", {irq, nmi}, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule